// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Transmitter

This block sends one packet onto a two-wire differential serial bus at the low-speed rate. On a `start` request it takes the data pair, drives the idle level and then clocks out a fixed sync byte. After the sync byte come the caller's bytes. Each byte goes out least significant bit first. The bits are NRZI-coded, and a stuffed bit is inserted after every run of six ones. The packet ends with an end-of-packet sequence, and then the block releases the pair. Bit timing comes from a one-cycle `bit_tick` strobe at the bus bit rate (nominally 1.5 Mbit/s). Between ticks the block holds its outputs.

The caller sets the total packet length on `pkt_len`. This length counts the sync byte. The caller presents bytes on `data_byte`. Each time `byte_take` pulses, the block latches the byte at that clock edge, and the caller moves on to the next byte. The pins are driven as two data levels plus one shared output enable. While the enable is low, the data levels rest at idle, so the level is already correct when the drivers turn on. `busy` covers the whole packet. `done` pulses once when the bus is released.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset and whenever no packet is in progress, `bus_oe`, `busy`, `done` and `byte_take` are 0, and the pins rest at idle J (`dp_out`=0, `dm_out`=1).
- R2: A `start` seen while idle raises `bus_oe` and `busy` on the next cycle with the pins still at J. The first bit appears only at the next `bit_tick`.
- R3: The sync byte 0x80 is sent first, followed by the caller's bytes, each least significant bit first. `byte_take` pulses exactly once per caller byte, which is length minus one pulses.
- R4: NRZI line coding: a 0 bit switches the line between J and K, and a 1 bit keeps it. K is `dp_out`=1, `dm_out`=0. Both pins high never occurs.
- R5: After six consecutive 1 bits, one extra toggle is inserted. The run count carries across byte boundaries, including out of the sync byte.
- R6: If the last data bits complete a run of six ones, the stuffed toggle is sent before the end of packet.
- R7: End of packet: both pins low for two bit times, then J for one bit time. At the next tick `bus_oe` and `busy` fall and `done` is high for exactly one cycle.
- R8: `pkt_len` is sampled at `start`. Values below 2 act as 2 and values above 12 act as 12.
- R9: `start` is ignored while a packet is in progress.
- R10: The pins change only in the cycle after a `bit_tick` (or on reset), whatever the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bus bit time |
| start | input | 1 | Request to send a packet |
| pkt_len | input | 4 | Packet length in bytes including sync |
| data_byte | input | 8 | Next caller byte |
| byte_take | output | 1 | Pulse: `data_byte` is latched at this edge |
| dp_out | output | 1 | Level for the D+ line |
| dm_out | output | 1 | Level for the D- line |
| bus_oe | output | 1 | Driver enable for both lines |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse when the bus is released |

## Verification
A reference model builds the expected line sequence from the byte list. It applies LSB-first order, six-ones stuffing and NRZI, then adds the end-of-packet sequence, and the model is compared with the pins every clock. All-zero bytes exercise pure toggling and show whether the 0/1 sense is inverted. Bytes of 0xFF exercise stuffing inside a byte and across a byte boundary. A final byte of 0xFC forces a stuff just before the end of packet. The sync byte's trailing 1 must merge with a following run, which shows whether the run counter is wrongly cleared at byte loads. Further cases cover lengths 0 and 15 against the clamp, a mid-packet `start`, and two tick spacings, which show whether outputs move between ticks.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam int         SE0_BITS  = 2;

    // {dp, dm}
    localparam logic [1:0] LN_SE0 = 2'b00;
    localparam logic [1:0] LN_J   = 2'b01;
    localparam logic [1:0] LN_K   = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_TAIL,
        ST_SE0,
        ST_EOPJ
    } tx_state_e;

    typedef struct packed {
        tx_state_e  st;
        logic [1:0] line;
        logic       oe;
        logic       done;
        logic       se0_cnt;
    } tx_regs_t;

    function automatic logic [1:0] flip_line(input logic [1:0] ln);
        return (ln == LN_J) ? LN_K : LN_J;
    endfunction

endpackage

// File: rtl/usb_ls_tx_feed.sv
module usb_ls_tx_feed
    import usb_ls_tx_pkg::*;
#(
    parameter int MIN_BYTES = 2,
    parameter int MAX_BYTES = 12,
    parameter int LEN_W     = 4,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [BYTE_W-1:0] data_byte,
    output logic              cur_bit,
    output logic              last_bit,
    output logic              byte_take
);
    localparam int IDX_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  left;
    } feed_t;

    feed_t cur_q, nx_d;
    logic [LEN_W-1:0] len_clamped;
    logic             byte_end;

    always_comb begin
        if (len_in < LEN_W'(MIN_BYTES))      len_clamped = LEN_W'(MIN_BYTES);
        else if (len_in > LEN_W'(MAX_BYTES)) len_clamped = LEN_W'(MAX_BYTES);
        else                                 len_clamped = len_in;
    end

    assign byte_end  = (cur_q.idx == IDX_W'(BYTE_W - 1));
    assign cur_bit   = cur_q.sh[0];
    assign last_bit  = byte_end && (cur_q.left == '0);
    assign byte_take = adv && byte_end && (cur_q.left != '0);

    always_comb begin
        nx_d = cur_q;
        if (load) begin
            nx_d.sh   = BYTE_W'(SYNC_BYTE);
            nx_d.idx  = '0;
            nx_d.left = len_clamped - LEN_W'(1);
        end else if (adv) begin
            if (byte_end) begin
                if (cur_q.left != '0) begin
                    nx_d.sh   = data_byte;
                    nx_d.idx  = '0;
                    nx_d.left = cur_q.left - LEN_W'(1);
                end
            end else begin
                nx_d.sh  = cur_q.sh >> 1;
                nx_d.idx = cur_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nx_d;
    end

endmodule

// File: rtl/usb_ls_tx_stuff.sv
module usb_ls_tx_stuff #(
    parameter int STUFF_RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_ev,
    input  logic bit_val,
    input  logic stuff_ev,
    output logic stuff_due
);
    localparam int CNT_W = $clog2(STUFF_RUN + 1);

    logic [CNT_W-1:0] run_q, run_d;

    always_comb begin
        run_d = run_q;
        if (clr || stuff_ev)  run_d = '0;
        else if (bit_ev)      run_d = bit_val ? run_q + CNT_W'(1) : '0;
    end

    assign stuff_due = (run_q == CNT_W'(STUFF_RUN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int MIN_BYTES = 2,
    parameter int MAX_BYTES = 12,
    parameter int STUFF_RUN = 6,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             start,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [7:0]       data_byte,
    output logic             byte_take,
    output logic             dp_out,
    output logic             dm_out,
    output logic             bus_oe,
    output logic             busy,
    output logic             done
);
    tx_regs_t cur_q, nx_d;

    logic load, adv, stuff_ev;
    logic cur_bit, last_bit, stuff_due;

    usb_ls_tx_feed #(
        .MIN_BYTES(MIN_BYTES),
        .MAX_BYTES(MAX_BYTES),
        .LEN_W    (LEN_W),
        .BYTE_W   (8)
    ) u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .len_in   (pkt_len),
        .data_byte(data_byte),
        .cur_bit  (cur_bit),
        .last_bit (last_bit),
        .byte_take(byte_take)
    );

    usb_ls_tx_stuff #(
        .STUFF_RUN(STUFF_RUN)
    ) u_stuff (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (load),
        .bit_ev   (adv),
        .bit_val  (cur_bit),
        .stuff_ev (stuff_ev),
        .stuff_due(stuff_due)
    );

    always_comb begin
        nx_d     = cur_q;
        nx_d.done = 1'b0;
        load     = 1'b0;
        adv      = 1'b0;
        stuff_ev = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                nx_d.line = LN_J;
                nx_d.oe   = 1'b0;
                if (start) begin
                    nx_d.st = ST_SEND;
                    nx_d.oe = 1'b1;
                    load    = 1'b1;
                end
            end
            ST_SEND: begin
                if (bit_tick) begin
                    if (stuff_due) begin
                        nx_d.line = flip_line(cur_q.line);
                        stuff_ev  = 1'b1;
                    end else begin
                        adv = 1'b1;
                        if (!cur_bit) nx_d.line = flip_line(cur_q.line);
                        if (last_bit) nx_d.st = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (bit_tick) begin
                    if (stuff_due) begin
                        nx_d.line = flip_line(cur_q.line);
                        stuff_ev  = 1'b1;
                    end else begin
                        nx_d.line    = LN_SE0;
                        nx_d.st      = ST_SE0;
                        nx_d.se0_cnt = 1'b0;
                    end
                end
            end
            ST_SE0: begin
                if (bit_tick) begin
                    if (cur_q.se0_cnt == 1'(SE0_BITS - 1)) begin
                        nx_d.line = LN_J;
                        nx_d.st   = ST_EOPJ;
                    end else begin
                        nx_d.se0_cnt = cur_q.se0_cnt + 1'b1;
                    end
                end
            end
            ST_EOPJ: begin
                if (bit_tick) begin
                    nx_d.st   = ST_IDLE;
                    nx_d.oe   = 1'b0;
                    nx_d.done = 1'b1;
                    nx_d.line = LN_J;
                end
            end
            default: begin
                nx_d.st   = ST_IDLE;
                nx_d.oe   = 1'b0;
                nx_d.line = LN_J;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.st   <= ST_IDLE;
            cur_q.line <= LN_J;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign dp_out = cur_q.line[1];
    assign dm_out = cur_q.line[0];
    assign bus_oe = cur_q.oe;
    assign busy   = (cur_q.st != ST_IDLE);
    assign done   = cur_q.done;

endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic byte_take,
    input logic dp_out,
    input logic dm_out,
    input logic bus_oe,
    input logic busy,
    input logic done
);
    // R1
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_oe && !byte_take));

    // R4
    no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_out && dm_out));

    // R2
    enable_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> (!dp_out && dm_out));

    // R7
    release_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> (!dp_out && dm_out && done));

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable({dp_out, dm_out}));

    // R3
    take_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> (busy && bit_tick));
endmodule

bind usb_ls_tx usb_ls_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .byte_take(byte_take),
    .dp_out   (dp_out),
    .dm_out   (dm_out),
    .bus_oe   (bus_oe),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_usb_ls_tx.sv
module tb_usb_ls_tx;
    localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;

    logic       clk = 0, rst_n = 0, bit_tick = 0, start = 0;
    logic [3:0] pkt_len = 0;
    logic [7:0] data_byte;
    logic       byte_take, dp_out, dm_out, bus_oe, busy, done;

    always #4 clk = ~clk;

    usb_ls_tx dut (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
        .pkt_len(pkt_len), .data_byte(data_byte), .byte_take(byte_take),
        .dp_out(dp_out), .dm_out(dm_out), .bus_oe(bus_oe), .busy(busy), .done(done));

    logic [7:0] pay [0:15];
    int take_idx = 0;
    assign data_byte = pay[take_idx[3:0]];

    int tests = 0, fails = 0, tick_per = 4;
    bit finished = 0;
    string cur_req = "R1";

    // reference model state
    logic [1:0] m_line = J;
    bit m_oe = 0, m_busy = 0, m_done = 0;
    logic [1:0] sym_q[$];
    int m_len = 0;

    task automatic build(input int len);
        int n, ones;
        logic [1:0] lvl;
        logic [7:0] b;
        n = (len < 2) ? 2 : (len > 12) ? 12 : len;
        m_len = n;
        sym_q.delete();
        ones = 0; lvl = J;
        for (int i = 0; i < n; i++) begin
            b = (i == 0) ? 8'h80 : pay[i-1];
            for (int k = 0; k < 8; k++) begin
                if (!b[k]) begin lvl = (lvl == J) ? K : J; ones = 0; end
                else ones++;
                sym_q.push_back(lvl);
                if (ones == 6) begin
                    lvl = (lvl == J) ? K : J; ones = 0;
                    sym_q.push_back(lvl);
                end
            end
        end
        sym_q.push_back(SE0); sym_q.push_back(SE0); sym_q.push_back(J);
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_line = J; m_oe = 0; m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (byte_take) take_idx <= take_idx + 1;
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_oe = 1; take_idx <= 0; build(int'(pkt_len));
                end
            end else if (bit_tick) begin
                if (sym_q.size() == 0) begin
                    m_oe = 0; m_busy = 0; m_done = 1; m_line = J;
                end else m_line = sym_q.pop_front();
            end
        end
    end

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t dp,dm,oe,busy,done act=%b exp=%b", req, $time, act, exp);
        end
    endtask

    // per-clock comparison against the model
    initial forever begin
        @(negedge clk);
        if (rst_n && !finished)
            check(cur_req, {dp_out, dm_out, bus_oe, busy, done},
                  {m_line, m_oe, m_busy, m_done});
    end

    // tick generator
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if (cnt >= tick_per) begin bit_tick = 1; cnt = 0; end
            else bit_tick = 0;
        end
    end

    task automatic send(input int len, input logic [7:0] b0, input logic [7:0] fill,
                        input logic [7:0] last);
        int n;
        n = (len < 2) ? 2 : (len > 12) ? 12 : len;
        for (int i = 0; i < 16; i++) pay[i] = fill;
        pay[0] = b0;
        pay[n-2] = last;
        @(negedge clk);
        pkt_len = 4'(len); start = 1;
        @(negedge clk);
        start = 0;
        // R2: one cycle after start, enabled at J, line unchanged
        check("R2", {dp_out, dm_out, bus_oe, busy, done}, {J, 1'b1, 1'b1, 1'b0});
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        // R3: one take per caller byte
        check("R3", 5'(take_idx), 5'(n - 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {dp_out, dm_out, bus_oe, busy, done, byte_take}[5:1],
              {J, 3'b000});
        check("R1", {4'b0, byte_take}, 5'b0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        cur_req = "R4"; send(2, 8'h00, 8'h00, 8'h00);
        cur_req = "R3"; send(4, 8'h55, 8'hA3, 8'h0F);
        cur_req = "R5"; send(4, 8'hFF, 8'hFF, 8'h7E);
        cur_req = "R5"; send(3, 8'h3F, 8'h3F, 8'h01);
        cur_req = "R6"; send(3, 8'h10, 8'h10, 8'hFC);
        cur_req = "R7"; send(5, 8'hC3, 8'h81, 8'hFE);
        cur_req = "R8"; send(0, 8'h5A, 8'h5A, 8'h5A);
        cur_req = "R8"; send(15, 8'h12, 8'hE7, 8'hFF);
        cur_req = "R10"; tick_per = 7; send(6, 8'h00, 8'hFF, 8'h33);
        tick_per = 4;
        // R9: start pulse mid-packet must be ignored
        cur_req = "R9";
        for (int i = 0; i < 16; i++) pay[i] = 8'h96;
        @(negedge clk); pkt_len = 4'd4; start = 1;
        @(negedge clk); start = 0;
        repeat (40) @(negedge clk);
        pkt_len = 4'd12; start = 1;
        @(negedge clk); start = 0;
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9", 5'(take_idx), 5'd3);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule